// File: doc/BRIEF.md
# Compare-and-Skip Execution Unit

This unit carries out one single-word instruction: it compares a byte held in a small internal register file with the working register and, when the byte is the smaller of the two, throws away the instruction that has already been fetched. The instruction's high byte selects the operation, and its low byte gives the register address. The compare is unsigned and is formed as a subtraction of the working register from the register byte. The borrow of that subtraction decides the skip. No flag is produced or altered.

Every instruction cycle is made of four phase clocks, counted Q1 to Q4. In an executing cycle the instruction is taken in during Q1. The register is read during Q2, the compare happens in Q3, and Q4 is idle. When the compare asks for a skip, the whole next cycle becomes a forced no-operation. In that cycle the prefetched instruction is marked as discarded, nothing is read, and nothing it encodes can request a further skip. The program counter advances once per cycle. So the next instruction that really executes sits one word past the compare without a skip, or two words past it with a skip.

The register file is loaded through a byte write port. The unit shows its read activity on a read-enable and read-address pair, so the phase in which it reads can be observed.

Top module: `cmpskip_unit`

## Requirements
- R1: An instruction whose upper byte is 0x30 is a compare-skip, and its low byte is the register address f (0 to 255). Any other upper byte never causes a skip and causes no register read.
- R2: A compare-skip requests a skip exactly when the byte at address f is smaller than the working register, both taken as unsigned 8-bit values.
- R3: When the byte equals the working register, or is greater than it, no skip takes place.
- R4: After a skip request, the next instruction cycle has fetch_discard=1 and fetch_valid=0 in all four phases. The discard rises only at phase 0. In every cycle without a request, fetch_valid=1 and fetch_discard=0.
- R5: During a forced no-operation cycle the presented instruction is not executed: it performs no register read, and even a compare-skip there leaves the following cycle valid.
- R6: phase counts 0,1,2,3 (Q1 to Q4) and wraps. pc_inc is high only in phase 3, and pc rises by one at the end of every instruction cycle, forced ones included.
- R7: rf_rd_en is high only in phase 1 of an executing compare-skip cycle, with rf_rd_addr equal to f.
- R8: If a compare-skip is presented when pc=A, the next cycle with fetch_valid=1 has pc=A+1 without a skip and pc=A+2 with a skip.
- R9: While reset is active and right after it is released: phase=0, pc=0, fetch_valid=1, fetch_discard=0, rf_rd_en=0.
- R10: A write-port access with rf_we=1 stores rf_wdata at rf_waddr on the rising clock edge, and a later compare sees the latest value written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Phase clock, four edges per instruction cycle |
| rst_n | input | 1 | Active-low synchronous reset |
| instr | input | 16 | Instruction word for the current cycle, taken in at the end of phase 0 |
| wreg | input | 8 | Working register value, used in phase 2 |
| rf_we | input | 1 | Register file write enable |
| rf_waddr | input | 8 | Register file write address |
| rf_wdata | input | 8 | Register file write data |
| phase | output | 2 | Current phase, 0 to 3 for Q1 to Q4 |
| fetch_valid | output | 1 | The instruction in this cycle executes |
| fetch_discard | output | 1 | The instruction in this cycle is discarded (forced no-operation) |
| pc_inc | output | 1 | Program counter advances at the end of this phase |
| pc | output | 16 | Program counter, the address of the instruction presented this cycle |
| rf_rd_en | output | 1 | Register file read in this phase |
| rf_rd_addr | output | 8 | Register file read address |

## Verification
On every cycle the assertions check the phase order and the single program counter step per cycle. They also check that reads occur only in phase 1 of executing cycles, that a discard starts at a cycle boundary, lasts a full cycle and never chains into a second one, and that a discard is only ever caused by a compare-skip opcode. The correctness of the unsigned decision itself (which byte and working-register pairs skip, the equal and extreme values, the effect of the latest write) and the address of the next executed instruction come only from the bench's random and directed scenarios, checked against its reference compare.

// File: rtl/cmpskip_unit.sv
module cmpskip_unit #(
  parameter int PC_W = 16,
  parameter int DW   = 8,
  parameter int AW   = 8,
  parameter logic [15-AW:0] OPC = 8'h30
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [15:0]     instr,
  input  logic [DW-1:0]   wreg,
  input  logic            rf_we,
  input  logic [AW-1:0]   rf_waddr,
  input  logic [DW-1:0]   rf_wdata,
  output logic [1:0]      phase,
  output logic            fetch_valid,
  output logic            fetch_discard,
  output logic            pc_inc,
  output logic [PC_W-1:0] pc,
  output logic            rf_rd_en,
  output logic [AW-1:0]   rf_rd_addr
);

  localparam int DEPTH = 1 << AW;

  logic [1:0]    q;
  logic [15:0]   ir;
  logic [DW-1:0] opnd;
  logic          lt_q;
  logic          nop_cyc;
  logic [DW-1:0] rf [DEPTH];
  logic [DW:0]   diff;

  wire ir_cmp = (ir[15:AW] == OPC);
  wire exec   = !nop_cyc;
  wire borrow = diff[DW];

  assign diff          = {1'b0, opnd} - {1'b0, wreg};
  assign phase         = q;
  assign fetch_valid   = exec;
  assign fetch_discard = nop_cyc;
  assign pc_inc        = (q == 2'd3);
  assign rf_rd_en      = (q == 2'd1) && exec && ir_cmp;
  assign rf_rd_addr    = ir[AW-1:0];

  always_ff @(posedge clk) begin
    if (rf_we) rf[rf_waddr] <= rf_wdata;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      q       <= 2'd0;
      ir      <= '0;
      opnd    <= '0;
      lt_q    <= 1'b0;
      nop_cyc <= 1'b0;
      pc      <= '0;
    end else begin
      q <= q + 2'd1;
      case (q)
        2'd0: ir <= instr;
        2'd1: if (rf_rd_en) opnd <= rf[rf_rd_addr];
        2'd2: lt_q <= exec && ir_cmp && borrow;
        default: begin
          nop_cyc <= lt_q;
          pc      <= pc + PC_W'(1);
        end
      endcase
    end
  end

  AST_PHASE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> phase == $past(phase) + 2'd1); // R6
  AST_PC_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    pc_inc |=> pc == $past(pc) + PC_W'(1)); // R6
  AST_PC_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !pc_inc |=> $stable(pc)); // R6
  AST_READ_Q2: assert property (@(posedge clk) disable iff (!rst_n)
    rf_rd_en |-> (phase == 2'd1) && fetch_valid); // R7
  AST_DISCARD_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(fetch_discard) |-> phase == 2'd0); // R4
  AST_DISCARD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    fetch_discard && (phase != 2'd3) |=> fetch_discard); // R4
  AST_NO_CHAIN: assert property (@(posedge clk) disable iff (!rst_n)
    fetch_discard && (phase == 2'd3) |=> !fetch_discard); // R5
  AST_SKIP_SRC: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(fetch_discard) |-> $past(ir_cmp)); // R1

endmodule

// File: tb/cmpskip_unit_bench.sv
module cmpskip_unit_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] instr = '0;
  logic [7:0]  wreg = '0;
  logic        rf_we = 1'b0;
  logic [7:0]  rf_waddr = '0;
  logic [7:0]  rf_wdata = '0;
  logic [1:0]  phase;
  logic        fetch_valid, fetch_discard, pc_inc, rf_rd_en;
  logic [15:0] pc;
  logic [7:0]  rf_rd_addr;

  int checks = 0;
  int errors = 0;
  int cyc = 0;

  cmpskip_unit u_cmpskip_unit (
    .clk(clk), .rst_n(rst_n), .instr(instr), .wreg(wreg),
    .rf_we(rf_we), .rf_waddr(rf_waddr), .rf_wdata(rf_wdata),
    .phase(phase), .fetch_valid(fetch_valid), .fetch_discard(fetch_discard),
    .pc_inc(pc_inc), .pc(pc), .rf_rd_en(rf_rd_en), .rf_rd_addr(rf_rd_addr)
  );

  always #5 clk = ~clk;

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      errors++;
      $display("FAIL watchdog: act %0d cycles exp fewer", cyc);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  function automatic bit is_cmp(input logic [15:0] i);
    return i[15:8] == 8'h30;
  endfunction

  function automatic bit ref_skip(input logic [15:0] i, input logic [7:0] f, input logic [7:0] w);
    return is_cmp(i) && (f < w);
  endfunction

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: act %0h exp %0h", req, what, act, exp);
    end
  endtask

  task automatic wait_p0();
    while (phase != 2'd0) @(negedge clk);
  endtask

  task automatic trial(input logic [15:0] i, input logic [7:0] f, input logic [7:0] w, input string req);
    logic [15:0] a;
    bit exp;
    exp = ref_skip(i, f, w);
    wait_p0();
    a = pc;
    instr = i; wreg = w;
    rf_we = 1'b1; rf_waddr = i[7:0]; rf_wdata = f;
    @(negedge clk);
    rf_we = 1'b0;
    chk(rf_rd_en == is_cmp(i), "R7", "read enable in phase 1", rf_rd_en, is_cmp(i));
    if (is_cmp(i)) chk(rf_rd_addr == i[7:0], "R7", "read address", rf_rd_addr, i[7:0]);
    repeat (3) @(negedge clk);
    chk(fetch_discard == exp, req, "skip decision", fetch_discard, exp);
    if (exp) begin
      instr = {8'h30, 8'($urandom)}; wreg = 8'hFF;
      chk(fetch_valid == 1'b0, "R4", "valid low in forced cycle", fetch_valid, 0);
      @(negedge clk);
      chk(rf_rd_en == 1'b0, "R5", "no read in forced cycle", rf_rd_en, 0);
      repeat (2) @(negedge clk);
      chk(fetch_discard == 1'b1, "R4", "discard held to phase 3", fetch_discard, 1);
      @(negedge clk);
      chk(fetch_valid == 1'b1, "R5", "forced cycle does not skip", fetch_valid, 1);
      chk(pc == a + 16'd2, "R8", "pc after skip", pc, a + 16'd2);
    end else begin
      instr = 16'h0000;
      chk(fetch_valid == 1'b1, "R4", "valid without skip", fetch_valid, 1);
      chk(pc == a + 16'd1, "R8", "pc without skip", pc, a + 16'd1);
    end
  endtask

  initial begin
    void'($urandom(32'd2024));
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(phase == 2'd0, "R9", "reset phase", phase, 0);
    chk(pc == 16'd0, "R9", "reset pc", pc, 0);
    chk(fetch_valid && !fetch_discard, "R9", "reset valid/discard", {fetch_valid, fetch_discard}, 2'b10);
    chk(rf_rd_en == 1'b0, "R9", "reset read enable", rf_rd_en, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(phase == 2'd1, "R9", "first phase after release", phase, 1);

    wait_p0();
    for (int k = 0; k < 4; k++) begin
      chk(phase == 2'(k), "R6", "phase order", phase, k);
      chk(pc_inc == (k == 3), "R6", "pc_inc only in phase 3", pc_inc, k == 3);
      @(negedge clk);
    end

    trial(16'h3000, 8'h00, 8'hFF, "R2");
    trial(16'h30FF, 8'hFF, 8'h00, "R3");
    trial(16'h3080, 8'h80, 8'h80, "R3");
    trial(16'h3011, 8'h00, 8'h00, "R3");
    trial(16'h3022, 8'hFF, 8'hFF, "R3");
    trial(16'h3033, 8'hFE, 8'hFF, "R2");
    trial(16'h3044, 8'h7F, 8'h80, "R2");
    trial(16'h3144, 8'h00, 8'hFF, "R1");
    trial(16'h2044, 8'h00, 8'hFF, "R1");
    trial(16'hB044, 8'h01, 8'h02, "R1");

    wait_p0();
    rf_we = 1'b1; rf_waddr = 8'h55; rf_wdata = 8'h10;
    @(negedge clk);
    rf_we = 1'b0;
    trial(16'h3055, 8'h50, 8'h20, "R10");

    for (int n = 0; n < 3000; n++) begin
      logic [7:0] f, w;
      logic [15:0] i;
      f = 8'($urandom);
      w = ($urandom % 8 == 0) ? f : 8'($urandom);
      i = ($urandom % 10 == 0) ? 16'($urandom) : {8'h30, 8'($urandom)};
      trial(i, f, w, is_cmp(i) ? ((f < w) ? "R2" : "R3") : "R1");
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule